// File: doc/BRIEF.md
# Header-Keyed Branch Outcome Replay Predictor

This block predicts conditional branches for a packet-processing engine. It relies on the fact that packets of the same flow tend to take the same path through the program. When a packet starts, a 32-bit key taken from its header is compared against every entry of a small fully associative table. Each entry holds a string of branch outcomes recorded from an earlier packet with the same key. On a match, the string is loaded into a shift register. Each conditional branch of the packet is then predicted by the next bit shifted out.

When the key is new, or the recorded string runs out partway through a packet, a small gshare predictor supplies the predictions instead. The gshare predictor is indexed by branch PC XOR global history. Resolved outcomes are always written back to the packet's entry, bit k for the k-th branch. This applies to a freshly allocated entry, to an entry being replayed (which corrects stale bits), and to the positions past the recorded length (which lengthens the string). The next packet of the flow therefore replays what actually happened.

Input protocol: `pkt_start` is never asserted in the same cycle as `br_req` or `res_valid`. Within a packet, branches resolve in the order they were requested, and a packet never has more resolves than requests.

Top module: `hdrkey_bpred`

## Requirements
- R1: On `pkt_start`, `pkt_key` is compared against all valid entries. At most one entry ever holds a given key, and a match makes the packet a hit.
- R2: On a miss, the entry at a round-robin pointer is taken over. The pointer starts at entry 0 after reset and advances by one per miss, wrapping after the last entry. The new entry holds the key and a recorded length of zero, so every branch of that packet is predicted by gshare (`pred_from_table` = 0).
- R3: Gshare has 128 two-bit counters, each reset to 1 (weakly not taken), and a 7-bit global history reset to 0. It is indexed by `pc[8:2]` XOR history, and it predicts taken when the counter's upper bit is 1. Every resolve steps the counter at `res_pc[8:2]` XOR the current history towards the outcome, saturating at 0 and 3, and then shifts the outcome into history bit 0. This happens even while the table is supplying the predictions.
- R4: On a hit, the k-th branch of the packet (k counted from 0) is predicted by bit k of the stored string, with `pred_from_table` = 1, while k is below the length recorded when the packet started.
- R5: Branches at or beyond that recorded length are predicted by gshare.
- R6: The k-th resolve of a packet writes its outcome into bit k of the packet's entry for k < HIST_BITS (128), and raises the recorded length to k+1 if it was lower. Resolves beyond HIST_BITS are not recorded, so in the next packet branch 128 onward comes from gshare.
- R7: A resolve that differs from the replayed bit overwrites that bit, so the next packet of the flow is predicted with the corrected outcome.
- R8: `pred_valid` pulses in the cycle after each `br_req` and is low otherwise. A branch may be requested in the cycle right after `pkt_start` and already sees that packet's lookup result.
- R9: Reset clears all entries, so every key misses afterwards, and holds `pred_valid`, `pred_taken` and `pred_from_table` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_start | input | 1 | Pulse marking the start of a packet |
| pkt_key | input | 32 | Header key for the starting packet |
| br_req | input | 1 | Prediction request for a conditional branch |
| br_pc | input | 32 | PC of the requested branch |
| res_valid | input | 1 | A branch of the current packet has resolved |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| pred_valid | output | 1 | Prediction is present this cycle |
| pred_taken | output | 1 | Predicted direction |
| pred_from_table | output | 1 | 1 when the prediction came from the stored string, 0 when from gshare |

## Verification
A wrong internal state surfaces at the ports only when a later packet reuses the affected state. A bad recorded bit or length is seen on the first replay of that flow, as a wrong `pred_taken` or a wrong `pred_from_table` at exactly the branch position concerned. A wrong victim pointer is seen when an evicted or surviving key comes back: it shows up as an unexpected source on that packet's first branch. A gshare counter or history error may stay hidden for several branches, so an independent bench model tracks the counters and history across every resolve, including those made during replay.

// File: rtl/hkbp_pkg.sv
package hkbp_pkg;

  typedef enum logic {
    SRC_GSHARE = 1'b0,
    SRC_TABLE  = 1'b1
  } pred_src_e;

  localparam logic [1:0] CTR_INIT = 2'b01;

  // Saturating two-bit counter step towards the outcome.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) begin
      return (c == 2'b11) ? c : c + 2'd1;
    end
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/hkbp_gshare.sv
module hkbp_gshare
  import hkbp_pkg::*;
#(
  parameter  int ENTRIES = 128,
  parameter  int PC_W    = 32,
  parameter  int PC_LSB  = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int DEPTH   = 1 << IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [1:0]       ctr_q [DEPTH];
  logic [1:0]       ctr_n [DEPTH];
  logic [IDX_W-1:0] ghr_q, ghr_n;
  logic [IDX_W-1:0] rd_idx, upd_idx;
  logic             pc_unused;

  assign pc_unused = ^{rd_pc, upd_pc};
  assign rd_idx    = rd_pc[PC_LSB +: IDX_W] ^ ghr_q;
  assign upd_idx   = upd_pc[PC_LSB +: IDX_W] ^ ghr_q;
  assign rd_taken  = ctr_q[rd_idx][1];

  always_comb begin
    ctr_n = ctr_q;
    ghr_n = ghr_q;
    if (upd_en) begin
      ctr_n[upd_idx] = ctr_step(ctr_q[upd_idx], upd_taken);
      ghr_n          = {ghr_q[IDX_W-2:0], upd_taken};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
      ghr_q <= '0;
    end else if (upd_en) begin
      ctr_q <= ctr_n;
      ghr_q <= ghr_n;
    end
  end

  // R3: history takes in each resolved outcome and is otherwise held
  a_r3_ghr_takes_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> ghr_q[0] == $past(upd_taken));
  a_r3_ghr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ghr_q));

endmodule

// File: rtl/hkbp_key_table.sv
module hkbp_key_table #(
  parameter  int ENTRIES   = 16,
  parameter  int KEY_W     = 32,
  parameter  int HIST_BITS = 128,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LEN_W     = $clog2(HIST_BITS + 1),
  localparam int POS_W     = $clog2(HIST_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 look_en,
  input  logic [KEY_W-1:0]     look_key,
  output logic                 look_hit,
  output logic [IDX_W-1:0]     look_idx,
  output logic [HIST_BITS-1:0] look_str,
  output logic [LEN_W-1:0]     look_len,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [POS_W-1:0]     wr_pos,
  input  logic                 wr_bit
);

  logic [ENTRIES-1:0]   vld_q, vld_n;
  logic [KEY_W-1:0]     key_q [ENTRIES];
  logic [KEY_W-1:0]     key_n [ENTRIES];
  logic [HIST_BITS-1:0] str_q [ENTRIES];
  logic [HIST_BITS-1:0] str_n [ENTRIES];
  logic [LEN_W-1:0]     len_q [ENTRIES];
  logic [LEN_W-1:0]     len_n [ENTRIES];
  logic [IDX_W-1:0]     rr_q, rr_n;
  logic [ENTRIES-1:0]   match;
  logic [IDX_W-1:0]     hit_idx;
  logic                 alloc;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (key_q[g] == look_key);
  end

  always_comb begin
    look_hit = 1'b0;
    hit_idx  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) begin
        look_hit = 1'b1;
        hit_idx  = IDX_W'(e);
      end
    end
  end

  assign look_idx = look_hit ? hit_idx : rr_q;
  assign look_str = str_q[look_idx];
  assign look_len = len_q[look_idx];
  assign alloc    = look_en && !look_hit;

  always_comb begin
    vld_n = vld_q;
    key_n = key_q;
    str_n = str_q;
    len_n = len_q;
    rr_n  = rr_q;
    if (alloc) begin
      vld_n[rr_q] = 1'b1;
      key_n[rr_q] = look_key;
      len_n[rr_q] = '0;
      rr_n        = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
    if (wr_en) begin
      str_n[wr_idx][wr_pos] = wr_bit;
      if (len_q[wr_idx] <= LEN_W'(wr_pos)) len_n[wr_idx] = LEN_W'(wr_pos) + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) len_q[i] <= '0;
    end else if (alloc || wr_en) begin
      vld_q <= vld_n;
      rr_q  <= rr_n;
      len_q <= len_n;
    end
  end

  // Storage arrays carry no reset: a key is qualified by its valid bit,
  // a string bit by the recorded length.
  always_ff @(posedge clk) begin
    if (alloc) key_q <= key_n;
    if (wr_en) str_q <= str_n;
  end

  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  a_r2_alloc_installs_key: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> vld_q[$past(rr_q)] && (key_q[$past(rr_q)] == $past(look_key)));
  a_r6_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    look_len <= LEN_W'(HIST_BITS));

endmodule

// File: rtl/hkbp_replay.sv
module hkbp_replay #(
  parameter  int HIST_BITS = 128,
  parameter  int IDX_W     = 4,
  localparam int LEN_W     = $clog2(HIST_BITS + 1),
  localparam int POS_W     = $clog2(HIST_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_start,
  input  logic                 look_hit,
  input  logic [IDX_W-1:0]     look_idx,
  input  logic [HIST_BITS-1:0] look_str,
  input  logic [LEN_W-1:0]     look_len,
  input  logic                 br_req,
  input  logic                 res_valid,
  output logic                 tbl_valid,
  output logic                 tbl_bit,
  output logic [IDX_W-1:0]     cur_idx,
  output logic                 rec_en,
  output logic [POS_W-1:0]     rec_pos
);

  logic                 active_q, active_n;
  logic [IDX_W-1:0]     cur_q, cur_n;
  logic [HIST_BITS-1:0] sr_q, sr_n;
  logic [LEN_W-1:0]     play_len_q, play_len_n;
  logic [LEN_W-1:0]     req_cnt_q, req_cnt_n;
  logic [LEN_W-1:0]     res_cnt_q, res_cnt_n;
  logic                 req_room, res_room;

  assign req_room  = req_cnt_q < LEN_W'(HIST_BITS);
  assign res_room  = res_cnt_q < LEN_W'(HIST_BITS);
  assign tbl_valid = active_q && (req_cnt_q < play_len_q);
  assign tbl_bit   = sr_q[0];
  assign cur_idx   = cur_q;
  assign rec_en    = res_valid && active_q && res_room;
  assign rec_pos   = res_cnt_q[POS_W-1:0];

  always_comb begin
    active_n   = active_q;
    cur_n      = cur_q;
    sr_n       = sr_q;
    play_len_n = play_len_q;
    req_cnt_n  = req_cnt_q;
    res_cnt_n  = res_cnt_q;
    if (pkt_start) begin
      active_n   = 1'b1;
      cur_n      = look_idx;
      sr_n       = look_hit ? look_str : '0;
      play_len_n = look_hit ? look_len : '0;
      req_cnt_n  = '0;
      res_cnt_n  = '0;
    end else begin
      if (br_req) begin
        sr_n = sr_q >> 1;
        if (req_room) req_cnt_n = req_cnt_q + LEN_W'(1);
      end
      if (res_valid && res_room) res_cnt_n = res_cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      cur_q      <= '0;
      play_len_q <= '0;
      req_cnt_q  <= '0;
      res_cnt_q  <= '0;
    end else if (pkt_start || br_req || res_valid) begin
      active_q   <= active_n;
      cur_q      <= cur_n;
      play_len_q <= play_len_n;
      req_cnt_q  <= req_cnt_n;
      res_cnt_q  <= res_cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (pkt_start || br_req) sr_q <= sr_n;
  end

  // R4: the replay length is fixed for the whole packet
  a_r4_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_start |=> $stable(play_len_q));
  // R6: recording never runs ahead of the branches requested
  a_r6_res_behind_req: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> res_cnt_q <= req_cnt_q);

endmodule

// File: rtl/hdrkey_bpred.sv
module hdrkey_bpred
  import hkbp_pkg::*;
#(
  parameter  int ENTRIES    = 16,
  parameter  int KEY_W      = 32,
  parameter  int HIST_BITS  = 128,
  parameter  int PC_W       = 32,
  parameter  int GS_ENTRIES = 128,
  parameter  int PC_LSB     = 2,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int LEN_W      = $clog2(HIST_BITS + 1),
  localparam int POS_W      = $clog2(HIST_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [KEY_W-1:0] pkt_key,
  input  logic             br_req,
  input  logic [PC_W-1:0]  br_pc,
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             pred_from_table
);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic                 look_hit;
  logic [IDX_W-1:0]     look_idx;
  logic [HIST_BITS-1:0] look_str;
  logic [LEN_W-1:0]     look_len;
  logic                 tbl_valid, tbl_bit;
  logic [IDX_W-1:0]     cur_idx;
  logic                 rec_en;
  logic [POS_W-1:0]     rec_pos;
  logic                 gs_taken;
  logic                 pv_q, pv_n;
  logic                 pt_q, pt_n;
  pred_src_e            ps_q, ps_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  hkbp_key_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .HIST_BITS(HIST_BITS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .look_en  (pkt_start),
    .look_key (pkt_key),
    .look_hit (look_hit),
    .look_idx (look_idx),
    .look_str (look_str),
    .look_len (look_len),
    .wr_en    (rec_en),
    .wr_idx   (cur_idx),
    .wr_pos   (rec_pos),
    .wr_bit   (res_taken)
  );

  hkbp_replay #(.HIST_BITS(HIST_BITS), .IDX_W(IDX_W)) u_replay (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pkt_start (pkt_start),
    .look_hit  (look_hit),
    .look_idx  (look_idx),
    .look_str  (look_str),
    .look_len  (look_len),
    .br_req    (br_req),
    .res_valid (res_valid),
    .tbl_valid (tbl_valid),
    .tbl_bit   (tbl_bit),
    .cur_idx   (cur_idx),
    .rec_en    (rec_en),
    .rec_pos   (rec_pos)
  );

  hkbp_gshare #(.ENTRIES(GS_ENTRIES), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_gshare (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rd_pc     (br_pc),
    .rd_taken  (gs_taken),
    .upd_en    (res_valid),
    .upd_pc    (res_pc),
    .upd_taken (res_taken)
  );

  always_comb begin
    pv_n = br_req;
    pt_n = 1'b0;
    ps_n = SRC_GSHARE;
    if (br_req) begin
      pt_n = tbl_valid ? tbl_bit : gs_taken;
      ps_n = tbl_valid ? SRC_TABLE : SRC_GSHARE;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pv_q <= 1'b0;
      pt_q <= 1'b0;
      ps_q <= SRC_GSHARE;
    end else begin
      pv_q <= pv_n;
      pt_q <= pt_n;
      ps_q <= ps_n;
    end
  end

  assign pred_valid      = pv_q;
  assign pred_taken      = pt_q;
  assign pred_from_table = (ps_q == SRC_TABLE);

  a_r8_pred_follows_req: assert property (@(posedge clk) disable iff (!rst_n_int)
    br_req |=> pred_valid);
  a_r8_no_spurious_pred: assert property (@(posedge clk) disable iff (!rst_n_int)
    !br_req |=> !pred_valid);
  a_r8_start_alone: assert property (@(posedge clk) disable iff (!rst_n_int)
    pkt_start |-> !br_req && !res_valid);

endmodule

// File: tb/hdrkey_bpred_test.sv
module hdrkey_bpred_test;

  localparam int NENT = 16;
  localparam int HB   = 128;
  localparam int GSE  = 128;
  // vector: {start, key select[1:0], pc[15:0], actual, tag[1:0]}
  // tag 0: R2 miss (gshare), 1: R4 replay, 2: R5 past length (gshare), 3: R7 corrected replay
  localparam logic [21:0] VEC [19] = '{
    {1'b1, 2'd0, 16'h0100, 1'b1, 2'd0}, {1'b0, 2'd0, 16'h0104, 1'b0, 2'd0},
    {1'b0, 2'd0, 16'h0108, 1'b1, 2'd0},
    {1'b1, 2'd0, 16'h0100, 1'b1, 2'd1}, {1'b0, 2'd0, 16'h0104, 1'b0, 2'd1},
    {1'b0, 2'd0, 16'h0108, 1'b1, 2'd1}, {1'b0, 2'd0, 16'h010C, 1'b1, 2'd2},
    {1'b1, 2'd1, 16'h0200, 1'b0, 2'd0}, {1'b0, 2'd1, 16'h0204, 1'b1, 2'd0},
    {1'b1, 2'd0, 16'h0100, 1'b1, 2'd1}, {1'b0, 2'd0, 16'h0104, 1'b1, 2'd1},
    {1'b0, 2'd0, 16'h0108, 1'b1, 2'd1}, {1'b0, 2'd0, 16'h010C, 1'b0, 2'd1},
    {1'b1, 2'd0, 16'h0100, 1'b1, 2'd3}, {1'b0, 2'd0, 16'h0104, 1'b1, 2'd3},
    {1'b0, 2'd0, 16'h0108, 1'b1, 2'd3}, {1'b0, 2'd0, 16'h010C, 1'b0, 2'd3},
    {1'b1, 2'd1, 16'h0200, 1'b0, 2'd1}, {1'b0, 2'd1, 16'h0204, 1'b1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_start = 1'b0;
  logic [31:0] pkt_key = '0;
  logic        br_req = 1'b0;
  logic [31:0] br_pc = '0;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic        pred_valid, pred_taken, pred_from_table;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // independent model of the requirements
  logic [31:0] m_key [NENT];
  bit          m_val [NENT];
  int          m_len [NENT];
  logic [HB-1:0] m_str [NENT];
  int          m_rr;
  int          m_ctr [GSE];
  int          m_ghr;
  int          c_idx, c_len, c_req, c_res;
  logic [HB-1:0] c_play;

  always #2 clk = ~clk;

  hdrkey_bpred uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_key(pkt_key),
    .br_req(br_req), .br_pc(br_pc), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_from_table(pred_from_table)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) begin m_val[i] = 0; m_len[i] = 0; m_str[i] = '0; m_key[i] = '0; end
    for (int i = 0; i < GSE; i++) m_ctr[i] = 1;
    m_rr = 0; m_ghr = 0; c_idx = 0; c_len = 0; c_req = 0; c_res = 0; c_play = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    check(pred_valid == 0, "R9", "pred_valid in reset", pred_valid, 0);
    check(pred_taken == 0, "R9", "pred_taken in reset", pred_taken, 0);
    check(pred_from_table == 0, "R9", "pred_from_table in reset", pred_from_table, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pred_valid == 0, "R9", "pred_valid after reset", pred_valid, 0);
    model_reset();
  endtask

  task automatic start_pkt(input logic [31:0] key);
    int hit;
    pkt_start = 1'b1;
    pkt_key   = key;
    @(negedge clk);
    pkt_start = 1'b0;
    hit = -1;
    for (int i = 0; i < NENT; i++) if (m_val[i] && m_key[i] == key) hit = i;
    if (hit >= 0) begin
      c_idx = hit; c_len = m_len[hit]; c_play = m_str[hit];
    end else begin
      c_idx = m_rr; m_key[m_rr] = key; m_val[m_rr] = 1; m_len[m_rr] = 0;
      m_rr = (m_rr + 1) % NENT; c_len = 0; c_play = '0;
    end
    c_req = 0; c_res = 0;
  endtask

  // exp_src: -1 none, 0 gshare, 1 table
  task automatic do_branch(input logic [31:0] pc, input bit actual,
                           input int exp_src, input string tag);
    bit e_taken, e_src;
    int gi;
    br_req = 1'b1;
    br_pc  = pc;
    @(negedge clk);
    br_req = 1'b0;
    gi = ((pc >> 2) & (GSE - 1)) ^ m_ghr;
    if (c_req < c_len) begin e_taken = c_play[c_req]; e_src = 1; end
    else begin e_taken = (m_ctr[gi] >= 2); e_src = 0; end
    if (c_req < HB) c_req++;
    check(pred_valid == 1, "R8", "pred_valid after req", pred_valid, 1);
    check(pred_from_table == e_src, tag, "source", pred_from_table, e_src);
    if (exp_src >= 0) check(pred_from_table == exp_src[0], tag, "listed source", pred_from_table, exp_src);
    check(pred_taken == e_taken, tag, "pred_taken", pred_taken, e_taken);
    res_valid = 1'b1; res_pc = pc; res_taken = actual;
    @(negedge clk);
    res_valid = 1'b0;
    check(pred_valid == 0, "R8", "pred_valid idle", pred_valid, 0);
    if (c_res < HB) begin
      m_str[c_idx][c_res] = actual;
      if (m_len[c_idx] < c_res + 1) m_len[c_idx] = c_res + 1;
      c_res++;
    end
    gi = ((pc >> 2) & (GSE - 1)) ^ m_ghr;
    if (actual) begin if (m_ctr[gi] < 3) m_ctr[gi]++; end
    else begin if (m_ctr[gi] > 0) m_ctr[gi]--; end
    m_ghr = ((m_ghr << 1) | int'(actual)) & (GSE - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R3: first gshare prediction from reset counters is not taken
    start_pkt(32'h0BAD_0000);
    do_branch(32'h40, 1'b1, 0, "R3");
    do_reset();

    // vector walk: R2 R4 R5 R7
    foreach (VEC[v]) begin
      string tg;
      int    es;
      case (VEC[v][1:0])
        2'd0: begin tg = "R2"; es = 0; end
        2'd1: begin tg = "R4"; es = 1; end
        2'd2: begin tg = "R5"; es = 0; end
        default: begin tg = "R7"; es = 1; end
      endcase
      if (VEC[v][21]) start_pkt(32'hC0DE_0000 + 32'(VEC[v][20:19]));
      do_branch({16'h0, VEC[v][18:3]}, VEC[v][2], es, tg);
    end

    // R6: record more branches than the string holds, then replay
    start_pkt(32'h5151_0000);
    for (int k = 0; k < HB + 2; k++)
      do_branch(32'h400 + 32'((k % 8) * 4), bit'(k[0] ^ k[2]), 0, "R6");
    start_pkt(32'h5151_0000);
    for (int k = 0; k < HB + 2; k++)
      do_branch(32'h400 + 32'((k % 8) * 4), bit'(k[0] ^ k[2]), (k < HB) ? 1 : 0, "R6");

    // R3: gshare keeps training while the table replays
    start_pkt(32'h5151_0000);
    for (int k = 0; k < 6; k++) do_branch(32'h80, 1'b1, 1, "R3");
    start_pkt(32'h7777_0000);
    for (int k = 0; k < 10; k++) do_branch(32'h80, 1'b1, 0, "R3");

    // R9: reset empties the table
    do_reset();
    start_pkt(32'hC0DE_0000);
    do_branch(32'h100, 1'b1, 0, "R9");

    // R1 R2: round-robin replacement over all entries
    do_reset();
    for (int i = 0; i <= NENT; i++) begin
      start_pkt(32'hD000_0000 + 32'(i));
      do_branch(32'h500, 1'b1, 0, "R2");
    end
    start_pkt(32'hD000_0001);
    do_branch(32'h500, 1'b0, 1, "R1");
    start_pkt(32'hD000_0000);
    do_branch(32'h500, 1'b1, 0, "R2");
    start_pkt(32'hD000_0002);
    do_branch(32'h500, 1'b1, 1, "R1");
    start_pkt(32'hD000_0001);
    do_branch(32'h500, 1'b0, 0, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule